// File: doc/BRIEF.md
# ALU Flag and Condition Evaluator

This block adds or subtracts two operands at a selectable width of 8, 16 or 32 bits and produces six status flags: carry, parity, auxiliary carry, zero, sign and overflow. A compare operation sets the flags exactly as a subtraction of the second operand from the first would, but leaves the stored result untouched. Both the result and the flags are captured only on a clock edge where the update strobe is high.

A 4-bit condition code is evaluated against the stored flags every cycle to give a taken or not-taken answer. Signed and unsigned orderings come only from combinations of the sign, overflow, carry and zero flags. A branch unit can therefore test the outcome of an earlier compare many cycles later, for as long as no further strobe overwrites the flags.

Top module: `alu_flag_cond`

## Requirements
- R1: While reset is asserted (rst_n low), the stored result and all six flags are zero.
- R2: The flags output is laid out as bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow. Flags and result change only on a rising edge where flag_we is 1; with flag_we at 0 both hold.
- R3: op_sel 0 adds and op_sel 1 subtracts (a minus b). op_size 0 works on bits 7:0, 1 on bits 15:0, and 2 or 3 on all 32 bits. The stored result is the truncated sum or difference, zero-extended to 32 bits, and operand bits above the active size have no effect.
- R4: op_sel 2 or 3 is a compare: flags are set exactly as for a subtraction, and the stored result keeps its previous value.
- R5: Carry is the carry out of the active size on an add and the borrow (a below b, unsigned) on a subtract or compare.
- R6: Zero is set when the truncated result is all zeros. Sign equals the top bit of the truncated result at the active size.
- R7: Overflow is set when the operation, read as signed at the active size, leaves the representable range.
- R8: Parity is set when bits 7:0 of the result hold an even number of ones. Auxiliary carry is the carry (add) or borrow (subtract) out of bit 3.
- R9: Condition codes are evaluated against the stored flags. Even codes 0,2,4,6,8,10,12,14 mean overflow, below, equal, below-or-equal, sign, parity, less, less-or-equal. An odd code is the complement of the code one lower. In a cycle where the strobe is high, cond_true still reflects the flags captured earlier.
- R10: Signed orderings: less is sign differs from overflow; less-or-equal is zero or less; greater-or-equal (13) and greater (15) are their complements.
- R11: Unsigned orderings: below is carry; below-or-equal is carry or zero; above-or-equal (3) and above (7) are their complements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 2 | 0 add, 1 subtract, 2 or 3 compare |
| op_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| flag_we | input | 1 | Capture strobe for result and flags |
| cond_code | input | 4 | Condition to evaluate |
| result | output | 32 | Stored result, zero-extended |
| flags | output | 6 | Stored flags |
| cond_true | output | 1 | Condition outcome on stored flags |

## Verification
The flag capture and the condition evaluation meet in the same cycle whenever the strobe is high while a condition is being tested. The bench holds the equal condition on cond_code during every strobe cycle and, before the edge, expects cond_true to reflect the zero flag of the previous operation; after the edge it sweeps all sixteen codes and judges them against unsigned and signed comparisons of the operands computed directly, not against flag formulas. Byte operations are swept over every first-operand value with stray upper bits set.

// File: rtl/alu_fc_pkg.sv
package alu_fc_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_SIZES = 3;
    localparam int BASE_W    = 8;
    localparam int CODE_W    = 4;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_CMP  = 2'd2,
        OP_CMPX = 2'd3
    } op_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zero;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    typedef enum logic [2:0] {
        CB_OVF = 3'd0,
        CB_BLW = 3'd1,
        CB_EQ  = 3'd2,
        CB_BLE = 3'd3,
        CB_SGN = 3'd4,
        CB_PAR = 3'd5,
        CB_LT  = 3'd6,
        CB_LE  = 3'd7
    } cond_base_e;

endpackage

// File: rtl/alu_fc_arith.sv
module alu_fc_arith
    import alu_fc_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int NSIZE = NUM_SIZES
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic [1:0]   size,
    output logic [W-1:0] res,
    output flags_t       fl
);

    localparam logic [1:0] TOP_SEL = 2'(NSIZE - 1);

    logic [W-1:0] lane_res [NSIZE];
    flags_t       lane_fl  [NSIZE];
    logic [1:0]   sel;

    for (genvar s = 0; s < NSIZE; s++) begin : g_lane
        localparam int LW = BASE_W << s;
        logic [LW:0] ext;

        always_comb begin
            if (sub) ext = {1'b0, a[LW-1:0]} - {1'b0, b[LW-1:0]};
            else     ext = {1'b0, a[LW-1:0]} + {1'b0, b[LW-1:0]};
            lane_res[s]     = W'(ext[LW-1:0]);
            lane_fl[s].cry  = ext[LW];
            lane_fl[s].sgn  = ext[LW-1];
            lane_fl[s].zero = (ext[LW-1:0] == '0);
            lane_fl[s].aux  = a[4] ^ b[4] ^ ext[4];
            lane_fl[s].par  = ~^ext[7:0];
            if (sub) lane_fl[s].ovf = (a[LW-1] ^ b[LW-1]) & (ext[LW-1] ^ a[LW-1]);
            else     lane_fl[s].ovf = ~(a[LW-1] ^ b[LW-1]) & (ext[LW-1] ^ a[LW-1]);
        end
    end

    always_comb begin
        sel = (size > TOP_SEL) ? TOP_SEL : size;
        res = lane_res[sel];
        fl  = lane_fl[sel];
    end

endmodule

// File: rtl/alu_fc_cond.sv
module alu_fc_cond
    import alu_fc_pkg::*;
(
    input  flags_t            fl,
    input  logic [CODE_W-1:0] code,
    output logic              hit
);

    logic       base;
    cond_base_e kind;

    always_comb begin
        kind = cond_base_e'(code[CODE_W-1:1]);
        unique case (kind)
            CB_OVF:  base = fl.ovf;
            CB_BLW:  base = fl.cry;
            CB_EQ:   base = fl.zero;
            CB_BLE:  base = fl.cry | fl.zero;
            CB_SGN:  base = fl.sgn;
            CB_PAR:  base = fl.par;
            CB_LT:   base = fl.sgn ^ fl.ovf;
            CB_LE:   base = fl.zero | (fl.sgn ^ fl.ovf);
            default: base = 1'b0;
        endcase
        hit = base ^ code[0];
    end

endmodule

// File: rtl/alu_flag_cond.sv
module alu_flag_cond
    import alu_fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       op_a,
    input  logic [31:0]       op_b,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        op_size,
    input  logic              flag_we,
    input  logic [3:0]        cond_code,
    output logic [31:0]       result,
    output logic [5:0]        flags,
    output logic              cond_true
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        flags_t            fl;
    } state_t;

    state_t            state_d, state_q;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_fl;
    op_e               op;

    assign op = op_e'(op_sel);

    alu_fc_arith #(.W(DATA_W), .NSIZE(NUM_SIZES)) u_arith (
        .a    (op_a),
        .b    (op_b),
        .sub  (op != OP_ADD),
        .size (op_size),
        .res  (alu_res),
        .fl   (alu_fl)
    );

    always_comb begin
        state_d = state_q;
        if (flag_we) begin
            state_d.fl = alu_fl;
            if (op == OP_ADD || op == OP_SUB) state_d.res = alu_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    alu_fc_cond u_cond (
        .fl   (state_q.fl),
        .code (cond_code),
        .hit  (cond_true)
    );

    assign result = state_q.res;
    assign flags  = state_q.fl;

endmodule

// File: rtl/alu_fc_chk.sv
module alu_fc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  op_sel,
    input logic [1:0]  op_size,
    input logic        flag_we,
    input logic [3:0]  cond_code,
    input logic [31:0] result,
    input logic [5:0]  flags,
    input logic        cond_true
);

    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> ($stable(flags) && $stable(result)));

    a_r4_compare_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel[1]) |=> $stable(result));

    a_r6_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !op_sel[1]) |=> (flags[3] == (result == 32'd0)));

    a_r6_sign_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !op_sel[1] && op_size == 2'd0) |=> (flags[4] == result[7]));

    a_r10_signed_ge: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd13) |-> (cond_true == (flags[4] == flags[5])));

    a_r11_unsigned_above: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd7) |-> (cond_true == !(flags[0] || flags[3])));

endmodule

bind alu_flag_cond alu_fc_chk u_chk (.*);

// File: tb/alu_flag_cond_test.sv
`timescale 1ns/1ps
module alu_flag_cond_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  op_sel = '0, op_size = '0;
    logic        flag_we = 1'b0;
    logic [3:0]  cond_code = '0;
    logic [31:0] result;
    logic [5:0]  flags;
    logic        cond_true;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_res = '0;
    logic [5:0]  exp_fl  = '0;

    alu_flag_cond uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .op_size(op_size), .flag_we(flag_we), .cond_code(cond_code),
        .result(result), .flags(flags), .cond_true(cond_true)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One operation: strobe for one edge, then check result, flags and all conditions.
    task automatic do_op(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] op, input logic [1:0] sz);
        int     n, cnt;
        longint mask, half, av, bv, full, r, sa, sb, sres;
        bit     sub, cry, par, aux, zero, sgn, ovf, base, expc;
        n    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask = (64'sd1 <<< n) - 1;
        half = 64'sd1 <<< (n - 1);
        sub  = (op != 2'd0);
        av   = longint'(a) & mask;
        bv   = longint'(b) & mask;
        full = sub ? av - bv : av + bv;
        r    = full & mask;
        cry  = sub ? (av < bv) : (full > mask);
        sa   = (av >= half) ? av - (mask + 1) : av;
        sb   = (bv >= half) ? bv - (mask + 1) : bv;
        sres = sub ? sa - sb : sa + sb;
        ovf  = (sres < -half) || (sres >= half);
        aux  = sub ? ((av & 15) < (bv & 15)) : (((av & 15) + (bv & 15)) > 15);
        cnt  = 0;
        for (int i = 0; i < 8; i++) cnt += int'((r >>> i) & 1);
        par  = (cnt % 2 == 0);
        zero = (r == 0);
        sgn  = ((r >>> (n - 1)) & 1) != 0;

        @(negedge clk);
        op_a = a; op_b = b; op_sel = op; op_size = sz; flag_we = 1'b1; cond_code = 4'd4;
        #1;
        // R9: during the strobe cycle the condition still reads the earlier flags
        chk(cond_true == exp_fl[3], "R9 same-cycle old flags", cond_true, exp_fl[3]);
        @(negedge clk);
        flag_we = 1'b0;
        exp_fl = {ovf, sgn, zero, aux, par, cry};
        if (op[1] == 1'b0) exp_res = 32'(r);
        chk(result == exp_res, op[1] ? "R4 compare holds result" : "R3 result", result, exp_res);
        chk(flags[0] == cry, "R5 carry", flags[0], cry);
        chk(flags[3] == zero && flags[4] == sgn, "R6 zero/sign", flags, exp_fl);
        chk(flags[5] == ovf, "R7 overflow", flags[5], ovf);
        chk(flags[1] == par && flags[2] == aux, "R8 parity/aux", flags, exp_fl);
        for (int c = 0; c < 16; c++) begin
            cond_code = 4'(c);
            #0.2;
            case (c / 2)
                0: base = ovf;
                1: base = sub ? (av < bv) : cry;
                2: base = sub ? (av == bv) : zero;
                3: base = sub ? (av <= bv) : (cry | zero);
                4: base = sgn;
                5: base = par;
                6: base = sub ? (sa < sb) : (sgn != ovf);
                default: base = sub ? (sa <= sb) : (zero | (sgn != ovf));
            endcase
            expc = base ^ c[0];
            if (c == 12 || c == 13 || c == 14 || c == 15)
                chk(cond_true == expc, "R10 signed order", cond_true, expc);
            else if (c == 2 || c == 3 || c == 6 || c == 7)
                chk(cond_true == expc, "R11 unsigned order", cond_true, expc);
            else
                chk(cond_true == expc, "R9 condition", cond_true, expc);
        end
    endtask

    logic [31:0] corners [8] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                                 32'hFFFF_FFFF, 32'h0000_7FFF, 32'h0000_8000, 32'h1234_F00F};

    initial begin
        #1_500_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        #12;
        // R1: reset state
        chk(result == 32'd0 && flags == 6'd0, "R1 reset", {flags, result}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Byte sweep with stray upper operand bits (R3)
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 16; j++)
                do_op(32'hDEAD_0000 | 32'(i), 32'hBEEF_0000 | 32'(j * 17),
                      2'((i + j) % 3), 2'd0);

        // Halfword and word corners, including size code 3 as word
        for (int s = 1; s < 4; s++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    do_op(corners[i], corners[j], 2'((i + j + s) % 4), 2'(s));

        // R2: no strobe, nothing changes
        @(negedge clk);
        op_a = 32'h5555_5555; op_b = 32'h0F0F_0F0F; op_sel = 2'd0; op_size = 2'd2;
        flag_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(result == exp_res, "R2 result held", result, exp_res);
        chk(flags == exp_fl, "R2 flags held", flags, exp_fl);

        summary();
    end

endmodule